// File: doc/BRIEF.md
# Scanline Horizontal Timing Generator

This block counts T-states across one video scanline of 224 states and decodes where the beam is within that line. The count advances only in cycles where the T-state enable is high, so the block can run from a fast system clock while it tracks a slower pixel-rate tick. Count zero is placed at the first state of active video, not at the start of sync. A CPU frame interrupt that must line up with the display start can therefore use the wrap to zero directly.

From the count it produces five region flags: active video, right border, horizontal sync, blanking and left border. Blanking covers the sync interval, so the sync and blank flags are both high during sync. It also produces two registered strobes. One marks the wrap to zero. The other marks entry into sync, which is the line boundary a vertical counter uses. Each strobe stays high for exactly one enable period.

Top module: `scanline_htiming`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the count reads 0. Both strobes are low, the video flag is high and every other region flag is low.
- R2: When the enable is high the count rises by one at each clock edge. When the enable is low the count holds.
- R3: When the count is 223 and the enable is high, the next value is 0. The count never exceeds 223.
- R4: The video flag is high exactly when the count is in 0..127.
- R5: The right-border flag is high exactly when the count is in 128..159.
- R6: The sync flag is high exactly when the count is in 160..175.
- R7: The blank flag is high exactly when the count is in 160..207. Sync therefore always implies blank.
- R8: The left-border flag is high exactly when the count is in 208..223.
- R9: The wrap strobe is high exactly while the count is 0 after it has been reached by an advance from 223. It stays high until the next enabled edge. It is never raised by reset.
- R10: The line-start strobe is high exactly while the count is 160 after an advance from 159. It stays high until the next enabled edge.
- R11: Reset has priority over the enable. A reset edge at count 223 with the enable high gives count 0 with the wrap strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ts_en | input | 1 | T-state advance enable |
| hcount | output | 8 | Horizontal position, 0..223 |
| vid_on | output | 1 | Active video region |
| rborder_on | output | 1 | Right border region |
| sync_on | output | 1 | Horizontal sync region |
| blank_on | output | 1 | Blanking region |
| lborder_on | output | 1 | Left border region |
| hrst_pulse | output | 1 | Wrap-to-zero strobe |
| line_start | output | 1 | Sync-entry strobe for a vertical counter |

## Verification
Two events can fall in the same cycle: a reset and the enabled wrap from 223 to 0. The bench runs the counter to 223 and then asserts reset together with the enable. It expects count 0 with the wrap strobe low, and expects the strobe to stay low on the following enabled step as well. The rest of the sweep runs whole lines both with the enable high every cycle and with a sparse enable pattern. Every output in every cycle is compared with a model that computes the regions arithmetically.

// File: rtl/scanline_htiming.sv
module scanline_htiming #(
  parameter int LINE_LEN  = 224,
  parameter int VID_LEN   = 128,
  parameter int RB_LEN    = 32,
  parameter int SYNC_LEN  = 16,
  parameter int BLANK_LEN = 48,
  localparam int CW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ts_en,
  output logic [CW-1:0] hcount,
  output logic          vid_on,
  output logic          rborder_on,
  output logic          sync_on,
  output logic          blank_on,
  output logic          lborder_on,
  output logic          hrst_pulse,
  output logic          line_start
);
  localparam logic [CW-1:0] LAST_C  = CW'(LINE_LEN - 1);
  localparam logic [CW-1:0] RB_C    = CW'(VID_LEN);
  localparam logic [CW-1:0] SYNC_C  = CW'(VID_LEN + RB_LEN);
  localparam logic [CW-1:0] SYNCE_C = CW'(VID_LEN + RB_LEN + SYNC_LEN);
  localparam logic [CW-1:0] LB_C    = CW'(VID_LEN + RB_LEN + BLANK_LEN);
  localparam logic [CW-1:0] PRE_C   = CW'(VID_LEN + RB_LEN - 1);

  logic at_last;
  assign at_last = (hcount == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount     <= '0;
      hrst_pulse <= 1'b0;
      line_start <= 1'b0;
    end else if (ts_en) begin
      hcount     <= at_last ? '0 : hcount + 1'b1;
      hrst_pulse <= at_last;
      line_start <= (hcount == PRE_C);
    end
  end

  assign vid_on     = hcount < RB_C;
  assign rborder_on = (hcount >= RB_C) && (hcount < SYNC_C);
  assign sync_on    = (hcount >= SYNC_C) && (hcount < SYNCE_C);
  assign blank_on   = (hcount >= SYNC_C) && (hcount < LB_C);
  assign lborder_on = hcount >= LB_C;
endmodule

// File: rtl/scanline_htiming_chk.sv
module scanline_htiming_chk #(
  parameter int LINE_LEN = 224,
  parameter int VID_LEN  = 128,
  parameter int RB_LEN   = 32,
  localparam int CW = $clog2(LINE_LEN)
) (
  input logic          clk,
  input logic          rst,
  input logic          ts_en,
  input logic [CW-1:0] hcount,
  input logic          vid_on,
  input logic          rborder_on,
  input logic          sync_on,
  input logic          blank_on,
  input logic          lborder_on,
  input logic          hrst_pulse,
  input logic          line_start
);
  localparam logic [CW-1:0] LAST_C = CW'(LINE_LEN - 1);
  localparam logic [CW-1:0] LS_C   = CW'(VID_LEN + RB_LEN);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (hcount == '0) && !hrst_pulse && !line_start);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ts_en |=> $stable(hcount));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ts_en && hcount != LAST_C) |=> hcount == $past(hcount) + 1'b1);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ts_en && hcount == LAST_C) |=> (hcount == '0) && hrst_pulse);

  assert_range_R3: assert property (@(posedge clk) disable iff (rst)
    hcount <= LAST_C);

  assert_one_region_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({vid_on, rborder_on, blank_on, lborder_on}) == 1);

  assert_sync_in_blank_R7: assert property (@(posedge clk) disable iff (rst)
    sync_on |-> blank_on);

  assert_hrst_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    hrst_pulse |-> (hcount == '0) && vid_on);

  assert_ls_at_sync_R10: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (hcount == LS_C) && sync_on);

  assert_reset_wins_R11: assert property (@(posedge clk)
    (rst && ts_en) |=> (hcount == '0) && !hrst_pulse);
endmodule

bind scanline_htiming scanline_htiming_chk #(
  .LINE_LEN(LINE_LEN), .VID_LEN(VID_LEN), .RB_LEN(RB_LEN)
) u_chk (.*);

// File: tb/tb_scanline_htiming.sv
`timescale 1ns/1ps
module tb_scanline_htiming;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts_en = 1'b0;
  logic [7:0] hcount;
  logic vid_on, rborder_on, sync_on, blank_on, lborder_on, hrst_pulse, line_start;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  bit eh = 0, el = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scanline_htiming dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (count model %0d)", tag, act, exp, ecnt);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 count", int'(hcount), ecnt);
    chk("R4 video", int'(vid_on), int'(ecnt < 128));
    chk("R5 right border", int'(rborder_on), int'(ecnt >= 128 && ecnt < 160));
    chk("R6 sync", int'(sync_on), int'(ecnt >= 160 && ecnt < 176));
    chk("R7 blank", int'(blank_on), int'(ecnt >= 160 && ecnt < 208));
    chk("R8 left border", int'(lborder_on), int'(ecnt >= 208));
    chk("R9 wrap strobe", int'(hrst_pulse), int'(eh));
    chk("R10 line start", int'(line_start), int'(el));
  endtask

  task automatic step(input logic r, input logic e);
    rst = r;
    ts_en = e;
    @(posedge clk);
    if (r) begin
      ecnt = 0; eh = 0; el = 0;
    end else if (e) begin
      eh = (ecnt == 223);
      el = (ecnt == 159);
      ecnt = (ecnt == 223) ? 0 : ecnt + 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    chk("R1 count", int'(hcount), 0);
    chk("R1 video", int'(vid_on), 1);
    chk("R1 wrap strobe", int'(hrst_pulse), 0);
    step(1'b0, 1'b0);
    chk("R1 held after release", int'(hcount), 0);
    for (int i = 0; i < 3 * 224; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 2 * 224 * 3; i++) step(1'b0, (i % 3) == 0);
    for (int i = 0; i < 200; i++) step(1'b0, (i % 5) != 2);
    while (ecnt != 223) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R11 reset beats wrap count", int'(hcount), 0);
    chk("R11 no strobe on reset", int'(hrst_pulse), 0);
    step(1'b0, 1'b1);
    chk("R11 next step", int'(hcount), 1);
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule